// File: doc/BRIEF.md
# Secondary-core boot release table

This block is a memory-mapped table with one boot slot for each secondary processor core. A boot master, usually the primary core, writes a start address and an argument into a waiting core's slot. While bit 0 of a slot's 64-bit start address is set, that core stays parked. Once an accepted write leaves the bit clear, the block fires a one-cycle launch pulse on that core's line.

Alongside the pulse, the block registers the launch parameters: the entry point (the start address reduced modulo the window size), the base of the initial memory window, and the argument. The window size is a fixed output. Slots use big-endian byte order. Software can read every byte of the table, and a launch writes the core's hardware ID into its slot so that software can see which cores have gone.

Top module: `spin_rel_ctrl`

## Requirements
- R1: After reset, slot k holds start address 1, argument k and core ID k, and every other byte is zero. The slot stride is 32 bytes. Within a slot, the start address is at bytes 0-7, the argument at bytes 8-15, a reserved word at bytes 16-19, the core ID at bytes 20-23 and a reserved doubleword at bytes 24-31, each stored most significant byte first.
- R2: A read of size 1, 2 or 4 (`bus_size`) at any byte address returns the bytes from that address upward, big-endian and zero-extended into `bus_rdata`. Addresses wrap at the end of the table. Any other size reads as zero.
- R3: A write of size 1, 2 or 4 stores `bus_wdata`'s low bytes most significant first, starting at `bus_addr`. A write of any other size, or a write whose last byte falls past the end of its slot, changes nothing.
- R4: A write to slot 0, or to a slot index at or above `num_cores`, changes nothing and launches nothing.
- R5: After every accepted write that leaves bit 0 of the slot's start address clear (bit 0 of byte 7), `launch_o[k]` is high for exactly the following cycle, where k is the slot index. No other bit is set.
- R6: With a launch pulse, `entry_pc_o` holds the start address modulo 2^WIN_LOG2, `win_base_o` holds the start address with its low WIN_LOG2 bits cleared, and `boot_arg_o` holds the argument. These values hold until the next launch. `win_size_o` is always 2^WIN_LOG2.
- R7: A launch of core k writes `core_hwid[32k+31:32k]` into slot k's core-ID bytes. This takes priority over the data of the write that caused the launch.
- R8: Any accepted write to a slot whose start bit 0 is clear launches that core again, even if the write only touches other fields. A launch or write to slot k leaves every other slot unchanged.
- R9: Slots at or above `num_cores` can still be read and return their stored bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| num_cores | input | CNT_W (6) | Number of cores present, 1 to MAX_CORES |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | ADDR_W (10) | Byte address in the table |
| bus_size | input | 3 | Access size in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Read data, right-aligned, combinational |
| core_hwid | input | 32*MAX_CORES | Hardware ID of each core |
| launch_o | output | MAX_CORES | One-cycle launch pulse per core |
| entry_pc_o | output | 64 | Entry point of the last launch |
| boot_arg_o | output | 64 | Argument of the last launch |
| win_base_o | output | 64 | Memory window base of the last launch |
| win_size_o | output | 64 | Memory window size |

## Verification
The assertions check on every cycle the properties that can be seen at the ports. The launch vector has at most one bit set and never bit 0. A pulse always follows a write whose slot index is present and whose bit position matches the pulse. The launch outputs change only together with a pulse, and a launched entry point is even. The assertions also check that unsupported read sizes return zero. Only the bench's reference model can show that the stored bytes are right: the big-endian lane placement, writes that are dropped, the core-ID overwrite, and repeated launches after rewrites.

// File: rtl/spin_rel_pkg.sv
package spin_rel_pkg;
   localparam int SLOT_BYTES = 32;
   localparam int SLOT_OFF_W = 5;
   localparam int HEAD_BYTES = 16;
   localparam int ID_OFF     = 20;
   localparam int ARG_OFF    = 8;
   localparam int START_LSB  = 7;

   typedef logic [SLOT_BYTES-1:0][7:0] slot_t;
   typedef logic [HEAD_BYTES-1:0][7:0] head_t;

   function automatic logic [2:0] legal_len(input logic [2:0] sz);
      return (sz == 3'd1 || sz == 3'd2 || sz == 3'd4) ? sz : 3'd0;
   endfunction

   function automatic logic [63:0] be_dword(input head_t h, input int base);
      logic [63:0] v;
      for (int i = 0; i < 8; i++) v[8*(7-i) +: 8] = h[base+i];
      return v;
   endfunction
endpackage

// File: rtl/spin_rel_lanes.sv
module spin_rel_lanes
   import spin_rel_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int IDX_W  = 5,
   parameter int CNT_W  = 6
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size,
   input  logic [31:0]       wdata,
   input  logic [CNT_W-1:0]  num_cores,
   output logic              accept,
   output logic [IDX_W-1:0]  slot_idx,
   output logic [SLOT_BYTES-1:0] lane_we,
   output slot_t             lane_wd
);
   logic [SLOT_OFF_W-1:0] off;
   logic [2:0]            len;
   logic [5:0]            end_pos;
   logic [3:0][7:0]       src;

   assign off      = addr[SLOT_OFF_W-1:0];
   assign slot_idx = addr[ADDR_W-1:SLOT_OFF_W];
   assign len      = legal_len(size);
   assign end_pos  = {1'b0, off} + {3'b000, len};

   always_comb begin
      accept = wr && (len != 3'd0) && (end_pos <= 6'd32) && (slot_idx != '0)
               && ({1'b0, slot_idx} < num_cores);
   end

   always_comb begin
      src = '0;
      case (len)
         3'd1: src[0] = wdata[7:0];
         3'd2: begin src[0] = wdata[15:8]; src[1] = wdata[7:0]; end
         3'd4: begin
            src[0] = wdata[31:24]; src[1] = wdata[23:16];
            src[2] = wdata[15:8];  src[3] = wdata[7:0];
         end
         default: src = '0;
      endcase
   end

   always_comb begin
      lane_we = '0;
      lane_wd = '0;
      for (int j = 0; j < SLOT_BYTES; j++) begin
         for (int r = 0; r < 4; r++) begin
            if (r < int'(len) && int'(off) + r == j) begin
               lane_we[j] = accept;
               lane_wd[j] = src[r];
            end
         end
      end
   end
endmodule

// File: rtl/spin_rel_entry.sv
module spin_rel_entry
   import spin_rel_pkg::*;
#(
   parameter int CORE_IDX = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel,
   input  logic [SLOT_BYTES-1:0] lane_we,
   input  slot_t                 lane_wd,
   input  logic                  go,
   input  logic [31:0]           hwid,
   output slot_t                 slot_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q            <= '0;
         slot_q[START_LSB] <= 8'd1;
         slot_q[ARG_OFF+7] <= 8'(CORE_IDX);
         slot_q[ID_OFF+3]  <= 8'(CORE_IDX);
      end else begin
         for (int j = 0; j < SLOT_BYTES; j++)
            if (sel && lane_we[j]) slot_q[j] <= lane_wd[j];
         if (go)
            for (int i = 0; i < 4; i++) slot_q[ID_OFF+i] <= hwid[8*(3-i) +: 8];
      end
   end
endmodule

// File: rtl/spin_rel_launch.sv
module spin_rel_launch
   import spin_rel_pkg::*;
#(
   parameter int MAX_CORES = 32,
   parameter int IDX_W     = 5,
   parameter int WIN_LOG2  = 26
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  accept,
   input  logic [IDX_W-1:0]      slot_idx,
   input  logic [HEAD_BYTES-1:0] head_we,
   input  head_t                 head_wd,
   input  head_t                 head_cur,
   output logic [MAX_CORES-1:0]  go_now,
   output logic [MAX_CORES-1:0]  launch_q,
   output logic [63:0]           pc_q,
   output logic [63:0]           arg_q,
   output logic [63:0]           base_q
);
   localparam logic [63:0] WIN_MASK = (64'd1 << WIN_LOG2) - 64'd1;

   head_t       merged;
   logic [63:0] start_addr;
   logic [63:0] arg_val;
   logic        go;

   always_comb begin
      for (int j = 0; j < HEAD_BYTES; j++)
         merged[j] = head_we[j] ? head_wd[j] : head_cur[j];
   end

   assign start_addr = be_dword(merged, 0);
   assign arg_val    = be_dword(merged, ARG_OFF);
   assign go         = accept && !start_addr[0];

   always_comb begin
      go_now = '0;
      if (go) go_now[slot_idx] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         launch_q <= '0;
         pc_q     <= '0;
         arg_q    <= '0;
         base_q   <= '0;
      end else begin
         launch_q <= go_now;
         if (go) begin
            pc_q   <= start_addr & WIN_MASK;
            base_q <= start_addr & ~WIN_MASK;
            arg_q  <= arg_val;
         end
      end
   end
endmodule

// File: rtl/spin_rel_ctrl.sv
module spin_rel_ctrl
   import spin_rel_pkg::*;
#(
   parameter int MAX_CORES = 32,
   parameter int WIN_LOG2  = 26,
   parameter int ADDR_W    = $clog2(MAX_CORES * SLOT_BYTES),
   parameter int CNT_W     = $clog2(MAX_CORES + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CNT_W-1:0]        num_cores,
   input  logic                    bus_wr,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [2:0]              bus_size,
   input  logic [31:0]             bus_wdata,
   output logic [31:0]             bus_rdata,
   input  logic [32*MAX_CORES-1:0] core_hwid,
   output logic [MAX_CORES-1:0]    launch_o,
   output logic [63:0]             entry_pc_o,
   output logic [63:0]             boot_arg_o,
   output logic [63:0]             win_base_o,
   output logic [63:0]             win_size_o
);
   localparam int IDX_W = ADDR_W - SLOT_OFF_W;

   if (MAX_CORES < 2 || MAX_CORES > 32 || (MAX_CORES & (MAX_CORES - 1)) != 0) begin : g_bad_cores
      $error("spin_rel_ctrl: MAX_CORES must be a power of two from 2 to 32");
   end
   if (WIN_LOG2 < 12 || WIN_LOG2 > 62) begin : g_bad_win
      $error("spin_rel_ctrl: WIN_LOG2 out of range");
   end
   if (ADDR_W != $clog2(MAX_CORES * SLOT_BYTES) || CNT_W != IDX_W + 1) begin : g_bad_w
      $error("spin_rel_ctrl: derived widths overridden inconsistently");
   end

   logic                  accept;
   logic [IDX_W-1:0]      slot_idx;
   logic [SLOT_BYTES-1:0] lane_we;
   slot_t                 lane_wd;
   logic [MAX_CORES-1:0]  go_now;
   slot_t                 slots [MAX_CORES];
   slot_t                 cur_slot;
   logic [3:0][7:0]       rb;
   logic [2:0]            rlen;

   spin_rel_lanes #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) lanes_i (
      .wr(bus_wr), .addr(bus_addr), .size(bus_size), .wdata(bus_wdata),
      .num_cores(num_cores), .accept(accept), .slot_idx(slot_idx),
      .lane_we(lane_we), .lane_wd(lane_wd)
   );

   for (genvar k = 0; k < MAX_CORES; k++) begin : g_slot
      spin_rel_entry #(.CORE_IDX(k)) entry_i (
         .clk(clk), .rst_n(rst_n),
         .sel(slot_idx == IDX_W'(k)),
         .lane_we(lane_we), .lane_wd(lane_wd),
         .go(go_now[k]), .hwid(core_hwid[32*k +: 32]),
         .slot_q(slots[k])
      );
   end

   assign cur_slot = slots[slot_idx];

   spin_rel_launch #(.MAX_CORES(MAX_CORES), .IDX_W(IDX_W), .WIN_LOG2(WIN_LOG2)) launch_i (
      .clk(clk), .rst_n(rst_n), .accept(accept), .slot_idx(slot_idx),
      .head_we(lane_we[HEAD_BYTES-1:0]), .head_wd(lane_wd[HEAD_BYTES-1:0]),
      .head_cur(cur_slot[HEAD_BYTES-1:0]),
      .go_now(go_now), .launch_q(launch_o),
      .pc_q(entry_pc_o), .arg_q(boot_arg_o), .base_q(win_base_o)
   );

   assign win_size_o = 64'd1 << WIN_LOG2;

   always_comb begin
      logic [ADDR_W-1:0] ba;
      for (int r = 0; r < 4; r++) begin
         ba    = bus_addr + ADDR_W'(r);
         rb[r] = slots[ba[ADDR_W-1:SLOT_OFF_W]][ba[SLOT_OFF_W-1:0]];
      end
   end

   assign rlen = legal_len(bus_size);

   always_comb begin
      case (rlen)
         3'd1:    bus_rdata = {24'd0, rb[0]};
         3'd2:    bus_rdata = {16'd0, rb[0], rb[1]};
         3'd4:    bus_rdata = {rb[0], rb[1], rb[2], rb[3]};
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spin_rel_chk.sv
module spin_rel_chk #(
   parameter int MAX_CORES = 32,
   parameter int ADDR_W    = 10,
   parameter int CNT_W     = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [CNT_W-1:0]     num_cores,
   input logic                 bus_wr,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [2:0]           bus_size,
   input logic [31:0]          bus_rdata,
   input logic [MAX_CORES-1:0] launch_o,
   input logic [63:0]          entry_pc_o,
   input logic [63:0]          boot_arg_o,
   input logic [63:0]          win_base_o
);
   // R5
   launch_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(launch_o));

   // R4
   primary_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !launch_o[0]);

   // R4
   launch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|launch_o) |-> $past(bus_wr)
         && ({1'b0, $past(bus_addr[ADDR_W-1:5])} < $past(num_cores)));

   // R5
   launch_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|launch_o) |-> launch_o[$past(bus_addr[ADDR_W-1:5])]);

   // R6
   params_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|launch_o) |-> ($stable(entry_pc_o) && $stable(boot_arg_o) && $stable(win_base_o)));

   // R6
   pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|launch_o) |-> !entry_pc_o[0]);

   // R2
   bad_size_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_size inside {3'd1, 3'd2, 3'd4}) |-> (bus_rdata == 32'd0));
endmodule

bind spin_rel_ctrl spin_rel_chk #(.MAX_CORES(MAX_CORES), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .num_cores(num_cores), .bus_wr(bus_wr),
   .bus_addr(bus_addr), .bus_size(bus_size), .bus_rdata(bus_rdata),
   .launch_o(launch_o), .entry_pc_o(entry_pc_o), .boot_arg_o(boot_arg_o),
   .win_base_o(win_base_o)
);

// File: tb/spin_rel_ctrl_tb.sv
module spin_rel_ctrl_tb_top;
   localparam int NC   = 32;
   localparam int WINL = 26;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [5:0]      num_cores = 6'd4;
   logic            bus_wr = 1'b0;
   logic [9:0]      bus_addr = '0;
   logic [2:0]      bus_size = 3'd1;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [32*NC-1:0] core_hwid;
   logic [NC-1:0]   launch_o;
   logic [63:0]     entry_pc_o, boot_arg_o, win_base_o, win_size_o;

   int n_tests = 0;
   int n_fail  = 0;
   int cycles  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   initial for (int k = 0; k < NC; k++) core_hwid[32*k +: 32] = 32'hC0DE_0000 | 32'(k);

   spin_rel_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .num_cores(num_cores), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .core_hwid(core_hwid), .launch_o(launch_o),
      .entry_pc_o(entry_pc_o), .boot_arg_o(boot_arg_o), .win_base_o(win_base_o),
      .win_size_o(win_size_o)
   );

   // behavioural reference model
   logic [7:0]    m [1024];
   logic [NC-1:0] x_launch;
   logic [63:0]   x_pc, x_arg, x_base;

   function automatic logic [63:0] m_dword(int a);
      logic [63:0] v = '0;
      for (int i = 0; i < 8; i++) v = (v << 8) | 64'(m[a+i]);
      return v;
   endfunction

   function automatic logic [31:0] m_read(int a, int s);
      logic [31:0] v = '0;
      if (s != 1 && s != 2 && s != 4) return 32'd0;
      for (int i = 0; i < s; i++) v = (v << 8) | 32'(m[(a+i) % 1024]);
      return v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) m[i] = 8'd0;
         for (int c = 0; c < NC; c++) begin
            m[c*32+7] = 8'd1; m[c*32+15] = 8'(c); m[c*32+23] = 8'(c);
         end
         x_launch = '0; x_pc = '0; x_arg = '0; x_base = '0;
      end else begin
         x_launch = '0;
         if (bus_wr) begin
            int idx, off, n;
            logic [63:0] sa;
            idx = int'(bus_addr) / 32;
            off = int'(bus_addr) % 32;
            n = (bus_size == 1 || bus_size == 2 || bus_size == 4) ? int'(bus_size) : 0;
            if (n != 0 && off + n <= 32 && idx != 0 && idx < int'(num_cores)) begin
               for (int r = 0; r < n; r++) m[int'(bus_addr)+r] = 8'(bus_wdata >> (8*(n-1-r)));
               sa = m_dword(idx*32);
               if (sa[0] == 1'b0) begin
                  x_launch[idx] = 1'b1;
                  x_pc   = sa % (64'd1 << WINL);
                  x_base = sa - x_pc;
                  x_arg  = m_dword(idx*32+8);
                  for (int i = 0; i < 4; i++)
                     m[idx*32+20+i] = 8'(core_hwid[32*idx +: 32] >> (8*(3-i)));
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      #1;
      if (rst_n && !done) begin
         n_tests++;
         if (bus_rdata !== m_read(int'(bus_addr), int'(bus_size))) begin
            n_fail++;
            $display("FAIL R2 model rdata: actual %h expected %h", bus_rdata,
                     m_read(int'(bus_addr), int'(bus_size)));
         end
         n_tests++;
         if (launch_o !== x_launch) begin
            n_fail++;
            $display("FAIL R5 model launch: actual %h expected %h", launch_o, x_launch);
         end
         n_tests++;
         if (entry_pc_o !== x_pc || win_base_o !== x_base || boot_arg_o !== x_arg
             || win_size_o !== (64'd1 << WINL)) begin
            n_fail++;
            $display("FAIL R6 model outputs: actual pc %h base %h arg %h expected pc %h base %h arg %h",
                     entry_pc_o, win_base_o, boot_arg_o, x_pc, x_base, x_arg);
         end
      end
   end

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic rd(input int a, input int s, input logic [31:0] exp, input string tag);
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 10'(a); bus_size = 3'(s);
      #2;
      chk(64'(bus_rdata), 64'(exp), tag);
   endtask

   task automatic wr(input int a, input int s, input logic [31:0] d,
                     input logic [NC-1:0] exp_l, input string tag);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 10'(a); bus_size = 3'(s); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      #2;
      chk(64'(launch_o), 64'(exp_l), tag);
   endtask

   task automatic outs(input logic [63:0] pc, input logic [63:0] base,
                       input logic [63:0] arg, input string tag);
      chk(entry_pc_o, pc, {tag, " pc"});
      chk(win_base_o, base, {tag, " base"});
      chk(boot_arg_o, arg, {tag, " arg"});
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000 && !done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk(64'(launch_o), 64'd0, "R1 launch idle");
      // R1 reset contents
      rd(3*32+7, 1, 32'h1, "R1 start lsb");
      rd(3*32+12, 4, 32'h3, "R1 arg");
      rd(2*32+20, 4, 32'h2, "R1 id");
      rd(5*32+16, 4, 32'h0, "R1 reserved");
      // R2 sizes and offsets
      rd(32+6, 2, 32'h0001, "R2 half");
      rd(32+7, 4, 32'h0100_0000, "R2 odd offset word");
      rd(32+4, 3, 32'h0, "R2 bad size");
      rd(1023, 2, 32'h0000, "R2 wrap");
      // R3 writes
      wr(32+8, 4, 32'h1122_3344, '0, "R3 arg write no launch");
      rd(32+8, 4, 32'h1122_3344, "R3 word stored");
      wr(32+12, 3, 32'hFFFF_FFFF, '0, "R3 bad size write");
      rd(32+12, 4, 32'h1, "R3 bad size no change");
      wr(32+30, 4, 32'hFFFF_FFFF, '0, "R3 cross slot write");
      rd(32+28, 4, 32'h0, "R3 cross slot no change");
      // R5 R6 R7 launch of core 1
      wr(32+0, 4, 32'h0000_0001, '0, "R5 upper word no launch");
      wr(32+4, 4, 32'h1234_5678, 32'h2, "R5 launch core1");
      outs(64'h0234_5678, 64'h0000_0001_1000_0000, 64'h1122_3344_0000_0001, "R6 core1");
      rd(32+20, 4, 32'hC0DE_0001, "R7 id written");
      chk(64'(launch_o), 64'd0, "R5 single cycle");
      rd(2*32+20, 4, 32'h2, "R8 other slot untouched");
      // R8 relaunch on rewrite of other fields
      wr(32+16, 1, 32'hAB, 32'h2, "R8 relaunch reserved write");
      wr(32+20, 4, 32'hDEAD_BEEF, 32'h2, "R8 relaunch id write");
      rd(32+20, 4, 32'hC0DE_0001, "R7 id priority");
      // R4 dropped writes
      wr(4, 4, 32'h0, '0, "R4 core0 write");
      rd(7, 1, 32'h1, "R4 core0 unchanged");
      wr(4*32+4, 4, 32'h0400_0000, '0, "R4 absent core write");
      rd(4*32+7, 1, 32'h1, "R9 absent slot readable");
      rd(4*32+15, 1, 32'h4, "R9 absent arg readable");
      num_cores = 6'd5;
      wr(4*32+4, 4, 32'h0400_0000, 32'h10, "R4 core4 present launch");
      outs(64'h0, 64'h0400_0000, 64'h4, "R6 core4");
      // R3 R5 narrow writes releasing
      wr(2*32+6, 2, 32'h0010, 32'h4, "R3 half write launch core2");
      outs(64'h10, 64'h0, 64'h2, "R6 core2");
      wr(3*32+7, 1, 32'h80, 32'h8, "R5 byte write launch core3");
      outs(64'h80, 64'h0, 64'h3, "R6 core3");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule